// File: doc/BRIEF.md
# SPI FIFO Level and Interrupt Controller

This block sits beside the serial engine of an SPI controller and owns its two word FIFOs (one for outgoing words, one for incoming words), the level comparison against programmable thresholds, and the interrupt logic. Software pushes outgoing words with a write strobe and pops incoming words with a read strobe. The serial engine pops outgoing words and pushes incoming words, and it reports one strobe per serial bit time.

Four interrupt sources are produced. Two are level requests that track FIFO occupancy: the transmit side asks for more data when its fill is low, and the receive side asks to be drained when its fill is high. The other two are sticky error flags: receive overflow, and receive timeout. Only the sticky flags can be cleared by a write-one-to-clear strobe. A mask input hides sources, and one combined interrupt line is the OR of the unmasked sources.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: A transmit push is stored when the transmit FIFO (DEPTH=256 words) is not full and is ignored when it is full. An engine pop removes the oldest word when the FIFO is not empty. `tx_rdata` always shows the oldest word, and `tx_level` gives the word count.
- R2: A receive pop removes the oldest received word when the FIFO is not empty. `rx_rdata` always shows the oldest word, and `rx_level` gives the word count. A receive push into a FIFO that is not full is stored.
- R3: A receive push that arrives while the receive FIFO is full is discarded, and raw bit 0 (overflow) is latched. A pop in the same cycle does not rescue the word.
- R4: A word counter restarts while the receive FIFO is empty or while `rx_pop` is high. Otherwise it counts `bit_tick` strobes. On the strobe that makes the count equal to a nonzero `timeout_bits`, raw bit 1 (timeout) is latched. A value of zero disables the timeout.
- R5: A 3-bit threshold code maps to a word level: 0→1, 1→4, 2→8, 3→16, 4→32, 5→64, 6→128, and 7 (reserved) acts as 128.
- R6: Raw bit 3 (transmit request) is high exactly while `tx_level` is less than or equal to the level selected by `tx_thr_code`.
- R7: Raw bit 2 (receive request) is high exactly while `rx_level` is greater than or equal to the level selected by `rx_thr_code`.
- R8: `fifo_stat` bit 0 = transmit empty, bit 1 = transmit not full, bit 2 = receive not empty, bit 3 = receive full, bit 4 = `engine_busy`. After reset both FIFOs are empty and both sticky flags are clear.
- R9: A cycle with `clr_wr` high clears overflow if `clr_data[0]` is 1 and clears timeout if `clr_data[1]` is 1. A new event in the same cycle wins over the clear. Raw bits 2 and 3 are not affected by the clear.
- R10: `masked_stat` equals `raw_stat` AND NOT `irq_mask`, where a mask bit of 1 hides its source. `irq` is high when any bit of `masked_stat` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Software writes one outgoing word |
| tx_wdata | input | DW | Outgoing word |
| tx_pop | input | 1 | Engine takes the oldest outgoing word |
| tx_rdata | output | DW | Oldest outgoing word |
| rx_push | input | 1 | Engine delivers one incoming word |
| rx_wdata | input | DW | Incoming word |
| rx_pop | input | 1 | Software reads the oldest incoming word |
| rx_rdata | output | DW | Oldest incoming word |
| engine_busy | input | 1 | Serial engine activity, reported in status |
| bit_tick | input | 1 | One pulse per serial bit time |
| tx_thr_code | input | 3 | Transmit threshold code |
| rx_thr_code | input | 3 | Receive threshold code |
| timeout_bits | input | TOW | Receive idle limit in bit times, 0 disables |
| irq_mask | input | 4 | Per-source mask, 1 hides the source |
| clr_wr | input | 1 | Clear strobe |
| clr_data | input | 2 | Clear bits: 0 overflow, 1 timeout |
| tx_level | output | AW+1 | Transmit word count |
| rx_level | output | AW+1 | Receive word count |
| fifo_stat | output | 5 | FIFO and busy status word |
| raw_stat | output | 4 | Unmasked interrupt sources |
| masked_stat | output | 4 | Masked interrupt sources |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a completely full receive FIFO that then takes further pushes, together with overflow clears and pops in the same cycle. Reaching it needs 256 back-to-back pushes without any read. The stimulus does this with a directed fill run. It then issues clears that coincide with overflowing pushes, and afterwards drains the FIFO while a behavioural queue model confirms the word order. The timeout window is reached by holding a word unread while bit strobes arrive, both with a nonzero limit and with a limit of zero.

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int TOW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic [DW-1:0]     tx_wdata,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_rdata,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_wdata,
  input  logic              rx_pop,
  output logic [DW-1:0]     rx_rdata,
  input  logic              engine_busy,
  input  logic              bit_tick,
  input  logic [2:0]        tx_thr_code,
  input  logic [2:0]        rx_thr_code,
  input  logic [TOW-1:0]    timeout_bits,
  input  logic [3:0]        irq_mask,
  input  logic              clr_wr,
  input  logic [1:0]        clr_data,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic [$clog2(DEPTH):0] rx_level,
  output logic [4:0]        fifo_stat,
  output logic [3:0]        raw_stat,
  output logic [3:0]        masked_stat,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic [CW-1:0] thr_level(input logic [2:0] code);
    int v;
    if (code == 3'd0)      v = 1;
    else if (code == 3'd7) v = 128;
    else                   v = 1 << (int'(code) + 1);
    return CW'(v);
  endfunction

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [TOW-1:0] idle_cnt;
  logic ovf_q, rto_q;

  wire tx_full  = (tx_cnt == FULL);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);
  wire tx_we = tx_push && !tx_full;
  wire tx_re = tx_pop && !tx_empty;
  wire rx_we = rx_push && !rx_full;
  wire rx_re = rx_pop && !rx_empty;
  wire ovf_set = rx_push && rx_full;
  wire rto_set = !rx_empty && !rx_pop && bit_tick && (timeout_bits != '0) &&
                 ({1'b0, idle_cnt} + 1'b1 == {1'b0, timeout_bits});

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_wp] <= tx_wdata;
    if (rx_we) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_we) tx_wp <= tx_wp + 1'b1;
      if (tx_re) tx_rp <= tx_rp + 1'b1;
      if (rx_we) rx_wp <= rx_wp + 1'b1;
      if (rx_re) rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_we) - CW'(tx_re);
      rx_cnt <= rx_cnt + CW'(rx_we) - CW'(rx_re);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      ovf_q <= 1'b0;
      rto_q <= 1'b0;
    end else begin
      if (rx_pop || rx_empty) idle_cnt <= '0;
      else if (bit_tick && idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
      if (ovf_set) ovf_q <= 1'b1;
      else if (clr_wr && clr_data[0]) ovf_q <= 1'b0;
      if (rto_set) rto_q <= 1'b1;
      else if (clr_wr && clr_data[1]) rto_q <= 1'b0;
    end
  end

  assign tx_rdata    = tx_mem[tx_rp];
  assign rx_rdata    = rx_mem[rx_rp];
  assign tx_level    = tx_cnt;
  assign rx_level    = rx_cnt;
  assign fifo_stat   = {engine_busy, rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw_stat    = {tx_cnt <= thr_level(tx_thr_code),
                        rx_cnt >= thr_level(rx_thr_code), rto_q, ovf_q};
  assign masked_stat = raw_stat & ~irq_mask;
  assign irq         = |masked_stat;

  a_r3_overflow_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full |=> raw_stat[0]);
  a_r3_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_pop |=> rx_level == $past(rx_level));
  a_r1_tx_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_full && !tx_pop |=> tx_level == $past(tx_level));
  a_r9_clear_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_data[0] && !(rx_push && rx_full) |=> !raw_stat[0]);
  a_r4_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat[1]) |-> $past(rx_level) != '0);
  a_r6_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level == '0 |-> raw_stat[3]);
  always_comb begin
    if (rst_n) a_r8_level_bound: assert (rx_level <= FULL && tx_level <= FULL);
  end
endmodule

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;
  localparam int DW = 32, DEPTH = 256, TOW = 16;

  logic clk = 0, rst_n = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic engine_busy = 0, bit_tick = 0, clr_wr = 0;
  logic [2:0] tx_thr_code = 0, rx_thr_code = 0;
  logic [TOW-1:0] timeout_bits = 0;
  logic [3:0] irq_mask = 0, raw_stat, masked_stat;
  logic [1:0] clr_data = 0;
  logic [8:0] tx_level, rx_level;
  logic [4:0] fifo_stat;
  logic irq;

  always #5 clk = ~clk;

  spi_fifo_irq_ctrl #(.DW(DW), .DEPTH(DEPTH), .TOW(TOW)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] txq[$], rxq[$];
  bit m_ovf = 0, m_rto = 0;
  int m_cnt = 0;
  int lvl_tab[8] = '{1, 4, 8, 16, 32, 64, 128, 128};

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); m_ovf = 0; m_rto = 0; m_cnt = 0;
    end else begin
      bit tpush, tpop, rpush, rpop, ne, rset, oset;
      tpush = tx_push && txq.size() < DEPTH;
      tpop  = tx_pop && txq.size() > 0;
      rpush = rx_push && rxq.size() < DEPTH;
      rpop  = rx_pop && rxq.size() > 0;
      oset  = rx_push && rxq.size() == DEPTH;
      ne    = rxq.size() > 0;
      rset  = ne && !rx_pop && bit_tick && timeout_bits != 0 && (m_cnt + 1 == int'(timeout_bits));
      if (rx_pop || !ne) m_cnt = 0;
      else if (bit_tick && m_cnt < 65535) m_cnt++;
      if (oset) m_ovf = 1; else if (clr_wr && clr_data[0]) m_ovf = 0;
      if (rset) m_rto = 1; else if (clr_wr && clr_data[1]) m_rto = 0;
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_wdata);
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_wdata);
      #1;
      if (rst_n && !done) begin
        logic [3:0] r;
        r = {txq.size() <= lvl_tab[tx_thr_code], rxq.size() >= lvl_tab[rx_thr_code], m_rto, m_ovf};
        check("R1 tx_level", tx_level, txq.size());
        if (txq.size() > 0) check("R1 tx_rdata", tx_rdata, txq[0]);
        check("R2 rx_level", rx_level, rxq.size());
        if (rxq.size() > 0) check("R2 rx_rdata", rx_rdata, rxq[0]);
        check("R3 overflow", raw_stat[0], m_ovf);
        check("R4 timeout", raw_stat[1], m_rto);
        check("R7 R5 rx request", raw_stat[2], r[2]);
        check("R6 R5 tx request", raw_stat[3], r[3]);
        check("R8 status", fifo_stat, {engine_busy, rxq.size() == DEPTH, rxq.size() > 0,
                                       txq.size() < DEPTH, txq.size() == 0});
        check("R10 masked", masked_stat, r & ~irq_mask);
        check("R10 irq", irq, |(r & ~irq_mask));
        check("R9 raw", raw_stat, r);
      end
    end
  end

  task automatic idle();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; bit_tick = 0; clr_wr = 0; clr_data = 0;
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; done = 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("R8 reset status", fifo_stat, 5'b00011);
    check("R8 reset raw", raw_stat, 4'b1000);
    check("R8 reset levels", {tx_level, rx_level}, 0);
    rst_n = 1;
    step();
    // R1 R6 fill tx past full with thresholds swept
    for (int i = 0; i < 260; i++) begin
      tx_push = 1; tx_wdata = 32'hA000_0000 + i; tx_thr_code = 3'(i / 37); step();
    end
    tx_pop = 1; tx_push = 1; step();
    idle();
    for (int i = 0; i < 130; i++) begin tx_pop = 1; tx_thr_code = 3'(i % 8); step(); end
    idle();
    // R3 fill rx beyond full
    for (int i = 0; i < 258; i++) begin
      rx_push = 1; rx_wdata = 32'h5000_0000 + i; rx_thr_code = 3'(i / 37); step();
    end
    clr_wr = 1; clr_data = 2'b01; step();     // R9 set wins over clear
    rx_pop = 1; step();                       // R3 pop with overflowing push
    rx_push = 0; rx_pop = 0; clr_wr = 1; clr_data = 2'b11; step();
    idle();
    for (int i = 0; i < 250; i++) begin rx_pop = 1; step(); end
    idle();
    // R4 timeout with limit 5 then disabled
    timeout_bits = 5;
    for (int i = 0; i < 12; i++) begin bit_tick = 1; step(); end
    clr_wr = 1; clr_data = 2'b10; bit_tick = 1; step();
    clr_wr = 0; clr_data = 0;
    for (int i = 0; i < 8; i++) begin bit_tick = 1; rx_pop = (i == 3); step(); end
    idle();
    timeout_bits = 0;
    for (int i = 0; i < 10; i++) begin bit_tick = 1; step(); end
    idle();
    // R10 mask sweep
    engine_busy = 1;
    for (int m = 0; m < 16; m++) begin irq_mask = 4'(m); step(); end
    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      int ph;
      ph = (i / 600) % 3;
      tx_push = ($urandom % 4) < (ph == 0 ? 3 : 1);
      tx_pop  = ($urandom % 4) < (ph == 1 ? 3 : 1);
      rx_push = ($urandom % 4) < (ph == 0 ? 3 : 1);
      rx_pop  = ($urandom % 8) < (ph == 2 ? 6 : 1);
      tx_wdata = $urandom; rx_wdata = $urandom;
      bit_tick = $urandom % 2;
      clr_wr = ($urandom % 16) == 0; clr_data = 2'($urandom);
      engine_busy = $urandom % 2;
      if (i % 50 == 0) begin
        tx_thr_code = 3'($urandom); rx_thr_code = 3'($urandom);
        irq_mask = 4'($urandom); timeout_bits = TOW'($urandom % 12);
      end
      step();
    end
    idle();
    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule